// File: doc/BRIEF.md
# Keyed Watchdog Timer with Write-Once Configuration

This block is a watchdog counter that advances on a slow oscillator tick enable. The tick is used either directly or after a fixed power-of-two prescaler. If software fails to service it in time, the counter overflows and the block emits a one-cycle internal reset request. The same request is raised whenever software touches the watchdog's registers in a way that is not allowed. Such accesses are: a second write to the configuration byte, any single-bit (read-modify-write) write, a wrong service key, and, in the stoppable option, a configuration byte whose fixed marker bits are wrong.

Software sees two byte registers through a simple access port. The configuration register can be written once after each reset. The service register clears the counter only when it receives the key 0xAC, and it always reads back as 0x9A. A static option strap selects one of two modes. In locked mode the timer can never be stopped and keeps counting through halt and stop. In stoppable mode a stop bit shuts the timer down for good, and halt/stop freeze the count without clearing it. When the source oscillator is reported as stopped, a pending reset request is kept and only issued once the oscillator runs again.

Top module: `keyed_wdt`

## Requirements
- R1: After any reset, the configuration register (select 0) accepts one whole-byte write. Every later write to it raises a reset request and leaves the stored byte as it was.
- R2: A write flagged as single-bit (`acc_bitop`=1) to either register never updates it and raises a reset request.
- R3: A whole-byte write of 0xAC to the service register (select 1) clears the counter and prescaler to zero. Any other written byte raises a reset request.
- R4: Reads of the service register return 0x9A. Reads of the configuration register return the stored byte, which is 0x67 after reset.
- R5: Configuration byte layout: bits [2:0] = span s, bit 3 = slow source, bit 4 = stop, bits [7:5] = marker 011. With the counter cleared and one tick per cycle, the reset request rises 2^(MIN_EXP+s) × (bit3 ? 2^DIV_EXP : 1) cycles after the clearing write.
- R6: In stoppable mode (`strap_locked`=0), a marker other than 011 raises a reset request. In locked mode the marker and stop bit are ignored: they are stored as 011 and 0, and the write is accepted.
- R7: While `src_run`=0, no reset request is issued; a violation is held pending. The request rises one cycle after `src_run` returns to 1. Accesses made while a request is pending are ignored.
- R8: In locked mode the counter keeps counting while `halt_in` or `stop_in` is high, and overflow still raises a reset request.
- R9: In stoppable mode, `halt_in` or `stop_in` freezes counter and prescaler. Counting resumes from the held value when both drop.
- R10: In stoppable mode a written stop bit stops the counter until the next reset: no overflow request follows. Correct key writes stay legal.
- R11: A reset request is a one-cycle pulse on `rst_req`, high in the cycle after the offending edge. With it, all state returns to default: write-once lock open, configuration 0x67, counter 0.
- R12: Until the configuration register is written, the longest span (s=7, direct source) is in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_locked | input | 1 | Option strap: 1 = locked mode, 0 = software-stoppable |
| src_run | input | 1 | 1 while the watchdog source oscillator runs |
| src_tick | input | 1 | One-cycle tick enable from the source oscillator |
| halt_in | input | 1 | CPU halt power mode active |
| stop_in | input | 1 | CPU stop power mode active |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_sel | input | 1 | 0 = configuration register, 1 = service register |
| acc_bitop | input | 1 | Access is a single-bit manipulation |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data for the selected register (combinational) |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
Register accesses are driven at a falling edge and sampled by the following rising edge. A violating access therefore shows `rst_req` high at the very next falling edge and low again one falling edge later. The bench samples exactly there. For overflow the bench gates `src_tick` off while configuring and counts falling edges from the clearing write. It expects the request after exactly span × prescale cycles, swept over all eight spans and both sources. A deferred request is checked low throughout the stopped window and high exactly one falling edge after `src_run` returns.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam logic [7:0] SVC_KEY   = 8'hAC;
  localparam logic [7:0] SVC_READ  = 8'h9A;
  localparam logic [2:0] MARK_BITS = 3'b011;

  typedef enum logic {
    SEL_CFG = 1'b0,
    SEL_SVC = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic [2:0] mark;
    logic       stop_sel;
    logic       slow_src;
    logic [2:0] span;
  } cfg_t;

  localparam cfg_t CFG_DEFAULT = '{mark: 3'b011, stop_sel: 1'b0, slow_src: 1'b0, span: 3'b111};

  // overflow period exponent for a given span
  function automatic int unsigned span_shift(input int unsigned base, input logic [2:0] span);
    return base + {29'd0, span};
  endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_locked,
  input  logic       blank,
  input  logic       soft_clr,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic       acc_sel,
  input  logic       acc_bitop,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  output cfg_t       cfg_o,
  output logic       key_clr_o,
  output logic       bad_acc_o
);

  cfg_t cfg_q, cfg_nxt;
  logic lock_q;
  logic wr_cfg, wr_svc, mark_ok, cfg_bad, svc_bad, cfg_take;

  assign wr_cfg  = acc_valid & acc_write & (acc_sel == SEL_CFG) & ~blank;
  assign wr_svc  = acc_valid & acc_write & (acc_sel == SEL_SVC) & ~blank;
  assign mark_ok = strap_locked | (acc_wdata[7:5] == MARK_BITS);

  assign cfg_bad   = wr_cfg & (acc_bitop | lock_q | ~mark_ok);
  assign svc_bad   = wr_svc & (acc_bitop | (acc_wdata != SVC_KEY));
  assign cfg_take  = wr_cfg & ~cfg_bad;
  assign key_clr_o = wr_svc & ~svc_bad;
  assign bad_acc_o = cfg_bad | svc_bad;

  always_comb begin
    cfg_nxt = cfg_t'(acc_wdata);
    if (strap_locked) begin
      cfg_nxt.mark     = MARK_BITS;
      cfg_nxt.stop_sel = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= CFG_DEFAULT;
      lock_q <= 1'b0;
    end else if (soft_clr) begin
      cfg_q  <= CFG_DEFAULT;
      lock_q <= 1'b0;
    end else if (cfg_take) begin
      cfg_q  <= cfg_nxt;
      lock_q <= 1'b1;
    end
  end

  assign acc_rdata = (acc_sel == SEL_SVC) ? SVC_READ : cfg_q;
  assign cfg_o     = cfg_q;

  // R1: once locked, the stored byte cannot move except by a reset request
  a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q && !soft_clr |=> $stable(cfg_q));

  // R2: a single-bit write never changes the configuration
  a_r2_bitop_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_write && acc_bitop && !soft_clr |=> $stable(cfg_q));

  // R6: locked mode always holds the fixed marker
  a_r6_mark_locked: assert property (@(posedge clk) disable iff (!rst_n)
    strap_locked |-> cfg_q.mark == MARK_BITS);

endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
  import kwdt_pkg::*;
#(
  parameter int unsigned MIN_EXP = 10,
  parameter int unsigned DIV_EXP = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       src_tick,
  input  logic       run_en,
  input  logic       slow_src,
  input  logic [2:0] span,
  input  logic       clr,
  output logic       ovf_o
);

  localparam int unsigned CW = MIN_EXP + 8;
  localparam int unsigned PW = (DIV_EXP > 0) ? DIV_EXP : 1;

  logic [CW-1:0] cnt_q, last_c;
  logic [PW-1:0] pre_q;
  logic          step_src, pre_wrap, step;

  assign step_src = src_tick & run_en;

  generate
    if (DIV_EXP == 0) begin : g_nodiv
      assign pre_wrap = step_src;
    end else begin : g_div
      assign pre_wrap = step_src & (pre_q == {PW{1'b1}});
    end
  endgenerate

  assign step   = slow_src ? pre_wrap : step_src;
  assign last_c = (CW'(1) << span_shift(MIN_EXP, span)) - CW'(1);
  assign ovf_o  = step & (cnt_q == last_c);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
      pre_q <= '0;
    end else begin
      if (step_src) pre_q <= pre_q + PW'(1);
      if (step)     cnt_q <= ovf_o ? '0 : cnt_q + CW'(1);
    end
  end

  // R9: with counting disabled the count is held
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en && !clr |=> $stable(cnt_q));

  // R3: a clear leaves the counter at zero
  a_r3_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt_q == '0);

endmodule

// File: rtl/kwdt_rstgen.sv
module kwdt_rstgen (
  input  logic clk,
  input  logic rst_n,
  input  logic src_run,
  input  logic evt,
  output logic fire_o,
  output logic blank_o,
  output logic rst_req_o
);

  logic pend_q, req_q;

  assign fire_o = (pend_q | evt) & src_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q  <= fire_o;
      pend_q <= fire_o ? 1'b0 : (pend_q | evt);
    end
  end

  assign blank_o   = pend_q | req_q;
  assign rst_req_o = req_q;

  // R7: no request follows a cycle with the source stopped
  a_r7_quiet_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !src_run |=> !rst_req_o);

  // R7: a pending event survives while the source is stopped
  a_r7_pending_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !src_run |=> pend_q);

  // R11: the request is a single-cycle pulse
  a_r11_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt
  import kwdt_pkg::*;
#(
  parameter int unsigned MIN_EXP = 10,
  parameter int unsigned DIV_EXP = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_locked,
  input  logic       src_run,
  input  logic       src_tick,
  input  logic       halt_in,
  input  logic       stop_in,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic       acc_sel,
  input  logic       acc_bitop,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  output logic       rst_req
);

  cfg_t cfg;
  logic key_clr, bad_acc, ovf, soft_clr, blank;
  logic stopped, paused, run_en, evt;

  assign stopped = cfg.stop_sel & ~strap_locked;
  assign paused  = ~strap_locked & (halt_in | stop_in);
  assign run_en  = src_run & ~stopped & ~paused;
  assign evt     = bad_acc | ovf;

  kwdt_regs u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .strap_locked (strap_locked),
    .blank        (blank),
    .soft_clr     (soft_clr),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_sel      (acc_sel),
    .acc_bitop    (acc_bitop),
    .acc_wdata    (acc_wdata),
    .acc_rdata    (acc_rdata),
    .cfg_o        (cfg),
    .key_clr_o    (key_clr),
    .bad_acc_o    (bad_acc)
  );

  kwdt_count #(.MIN_EXP(MIN_EXP), .DIV_EXP(DIV_EXP)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_tick (src_tick),
    .run_en   (run_en),
    .slow_src (cfg.slow_src),
    .span     (cfg.span),
    .clr      (key_clr | soft_clr),
    .ovf_o    (ovf)
  );

  kwdt_rstgen u_rstgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_run   (src_run),
    .evt       (evt),
    .fire_o    (soft_clr),
    .blank_o   (blank),
    .rst_req_o (rst_req)
  );

  // R10: a stopped watchdog never overflows
  a_r10_no_ovf_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    stopped |-> !ovf);

endmodule

// File: tb/keyed_wdt_bench.sv
`timescale 1ns/1ps
module keyed_wdt_bench;

  localparam int unsigned MIN_EXP = 2;
  localparam int unsigned DIV_EXP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_locked = 1'b0, src_run = 1'b1, src_tick = 1'b0;
  logic halt_in = 1'b0, stop_in = 1'b0;
  logic acc_valid = 1'b0, acc_write = 1'b0, acc_sel = 1'b0, acc_bitop = 1'b0;
  logic [7:0] acc_wdata = 8'h00;
  logic [7:0] acc_rdata;
  logic rst_req;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  keyed_wdt #(.MIN_EXP(MIN_EXP), .DIV_EXP(DIV_EXP)) u_keyed_wdt (
    .clk(clk), .rst_n(rst_n), .strap_locked(strap_locked), .src_run(src_run),
    .src_tick(src_tick), .halt_in(halt_in), .stop_in(stop_in),
    .acc_valid(acc_valid), .acc_write(acc_write), .acc_sel(acc_sel),
    .acc_bitop(acc_bitop), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
    .rst_req(rst_req)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hw_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // called at a falling edge; returns at the falling edge after the sampling edge
  task automatic wr(input logic sel, input logic bitop, input logic [7:0] d);
    acc_valid = 1'b1; acc_write = 1'b1; acc_sel = sel; acc_bitop = bitop; acc_wdata = d;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0; acc_bitop = 1'b0;
  endtask

  task automatic rd(input logic sel, output int v);
    acc_sel = sel;
    #1;
    v = int'(acc_rdata);
  endtask

  task automatic wait_req(input int lim, output int n);
    n = 0;
    while (!rst_req && n < lim) begin
      @(negedge clk);
      n++;
    end
  endtask

  // let an active pulse end, then confirm it lasted one cycle
  task automatic pulse_done(input string req);
    @(negedge clk);
    check(req, int'(rst_req), 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int v, n;
    hw_reset();

    // R11 / R4 / R12: reset state
    check("R11 reset idle", int'(rst_req), 0);
    rd(1'b0, v); check("R4 cfg default", v, 'h67);
    rd(1'b1, v); check("R4 svc read", v, 'h9A);

    // R12: default span, direct source: 2^(2+7) cycles
    src_tick = 1'b0;
    wr(1'b1, 1'b0, 8'hAC);
    src_tick = 1'b1;
    wait_req(2000, n);
    check("R12 default span", n, 512);
    pulse_done("R11 pulse width");
    rd(1'b0, v); check("R11 cfg back to default", v, 'h67);

    // R5: sweep every span and both sources
    for (int s = 0; s < 8; s++) begin
      for (int cs = 0; cs < 2; cs++) begin
        logic [7:0] b;
        b = {3'b011, 1'b0, cs[0], s[2:0]};
        src_tick = 1'b0;
        wr(1'b0, 1'b0, b);
        check("R5 cfg write legal", int'(rst_req), 0);
        rd(1'b0, v); check("R5 cfg readback", v, int'(b));
        wr(1'b1, 1'b0, 8'hAC);
        src_tick = 1'b1;
        wait_req(4096, n);
        check("R5 overflow period", n, (1 << (MIN_EXP + s)) * (cs ? (1 << DIV_EXP) : 1));
        pulse_done("R11 pulse after overflow");
      end
    end
    src_tick = 1'b0;

    // R1: write once
    hw_reset();
    wr(1'b0, 1'b0, 8'h63);
    check("R1 first write legal", int'(rst_req), 0);
    wr(1'b0, 1'b0, 8'h64);
    check("R1 second write resets", int'(rst_req), 1);
    pulse_done("R11 pulse after second write");
    rd(1'b0, v); check("R11 lock released cfg", v, 'h67);
    wr(1'b0, 1'b0, 8'h62);
    check("R11 write after pulse legal", int'(rst_req), 0);
    rd(1'b0, v); check("R1 write after pulse stored", v, 'h62);

    // R2: single-bit writes
    hw_reset();
    wr(1'b0, 1'b1, 8'h63);
    check("R2 bitop cfg resets", int'(rst_req), 1);
    pulse_done("R11 pulse bitop cfg");
    rd(1'b0, v); check("R2 cfg not updated", v, 'h67);
    wr(1'b1, 1'b1, 8'hAC);
    check("R2 bitop svc resets", int'(rst_req), 1);
    pulse_done("R11 pulse bitop svc");

    // R3: every service byte value
    for (int k = 0; k < 256; k++) begin
      wr(1'b1, 1'b0, k[7:0]);
      check("R3 key decode", int'(rst_req), (k == 'hAC) ? 0 : 1);
      if (rst_req) @(negedge clk);
    end

    // R3: key write restarts the count
    wr(1'b0, 1'b0, 8'h60);
    wr(1'b1, 1'b0, 8'hAC);
    src_tick = 1'b1;
    repeat (2) @(negedge clk);
    wr(1'b1, 1'b0, 8'hAC);
    wait_req(100, n);
    check("R3 key clears count", n, 4);
    pulse_done("R11 pulse after restart");
    src_tick = 1'b0;

    // R6: marker handling
    wr(1'b0, 1'b0, 8'h43);
    check("R6 bad marker stoppable", int'(rst_req), 1);
    pulse_done("R11 pulse bad marker");
    strap_locked = 1'b1;
    hw_reset();
    wr(1'b0, 1'b0, 8'h13);
    check("R6 marker ignored locked", int'(rst_req), 0);
    rd(1'b0, v); check("R6 locked stored byte", v, 'h63);
    wr(1'b1, 1'b0, 8'hAC);
    src_tick = 1'b1;
    wait_req(200, n);
    check("R6 stop bit ignored locked", n, 32);
    pulse_done("R11 pulse locked");
    src_tick = 1'b0;

    // R8: locked mode counts through halt and stop
    wr(1'b0, 1'b0, 8'h60);
    wr(1'b1, 1'b0, 8'hAC);
    halt_in = 1'b1; stop_in = 1'b1; src_tick = 1'b1;
    wait_req(100, n);
    check("R8 locked counts in low power", n, 4);
    pulse_done("R11 pulse R8");
    halt_in = 1'b0; stop_in = 1'b0; src_tick = 1'b0;

    // R9: stoppable mode pauses and resumes
    strap_locked = 1'b0;
    for (int w = 0; w < 2; w++) begin
      hw_reset();
      wr(1'b0, 1'b0, 8'h60);
      wr(1'b1, 1'b0, 8'hAC);
      src_tick = 1'b1;
      repeat (2) @(negedge clk);
      if (w == 0) halt_in = 1'b1; else stop_in = 1'b1;
      repeat (10) @(negedge clk);
      check("R9 paused no request", int'(rst_req), 0);
      halt_in = 1'b0; stop_in = 1'b0;
      wait_req(100, n);
      check("R9 resumed from held value", n, 2);
      pulse_done("R11 pulse R9");
      src_tick = 1'b0;
    end

    // R10: permanent stop
    hw_reset();
    wr(1'b0, 1'b0, 8'h70);
    src_tick = 1'b1;
    wait_req(600, n);
    check("R10 stopped no overflow", n, 600);
    wr(1'b1, 1'b0, 8'hAC);
    check("R10 key legal when stopped", int'(rst_req), 0);
    repeat (20) @(negedge clk);
    check("R10 still quiet", int'(rst_req), 0);
    wr(1'b1, 1'b0, 8'h00);
    check("R3 wrong key while stopped", int'(rst_req), 1);
    pulse_done("R11 pulse R10");
    src_tick = 1'b0;

    // R7: deferred request
    hw_reset();
    src_run = 1'b0;
    wr(1'b1, 1'b0, 8'h11);
    check("R7 deferred at once", int'(rst_req), 0);
    repeat (20) @(negedge clk);
    check("R7 deferred held", int'(rst_req), 0);
    src_run = 1'b1;
    @(negedge clk);
    check("R7 issued on resume", int'(rst_req), 1);
    pulse_done("R11 pulse R7");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule